// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a synchronous on-chip master read and write one external asynchronous static RAM of 65,536 words by 4 bits. The master hands over one word at a time on a valid/ready request port: a 16-bit address, 4 bits of write data and a write flag. The controller then plays the memory's active-low select, write and output strobes in a fixed order and reports completion with a single-cycle done pulse. For a read, the word is returned on the same pulse.

Every transfer runs through five phases. First comes an idle cycle with the memory deselected. Next is a setup cycle in which only the address (and, for a write, the data) is presented. Then come the strobed access cycles, whose count is a parameter chosen so that the memory's access time fits the clock period. A write adds one hold cycle. Last is a recovery cycle with every strobe released. The shared data pin is split into an output value, a drive enable and an input value. The pad ring joins them into the bidirectional pins, and the drive enable is never active while the memory's outputs are turned on.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and for as long as no request is accepted, mem_ce_n, mem_we_n and mem_oe_n are all 1, mem_dq_drive is 0, req_ready is 1 and rsp_done is 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle through the done cycle. Changes on req_addr, req_wdata and req_write after acceptance have no effect on that transfer.
- R3: The accepted address is on mem_addr one full cycle before mem_ce_n falls. It stays unchanged in the cycle mem_ce_n falls.
- R4: A write holds mem_ce_n and mem_we_n low together for exactly WR_WAIT cycles. mem_oe_n stays 1 and mem_dq_drive stays 1 during those cycles.
- R5: At the end of a write, mem_we_n rises one cycle before mem_ce_n. In that hold cycle, mem_addr and mem_dq_out are unchanged and still driven.
- R6: A read holds mem_ce_n and mem_oe_n low together for exactly RD_WAIT cycles. mem_we_n stays 1 and mem_dq_drive stays 0 during those cycles.
- R7: Read data is sampled from mem_dq_in at the end of the last of the RD_WAIT cycles. It is shown on rsp_rdata in the done cycle.
- R8: Counting the accepting cycle as cycle 0, rsp_done is 1 in cycle RD_WAIT+2 for a read and in cycle WR_WAIT+3 for a write.
- R9: In the done cycle all three strobes are 1 and mem_dq_drive is 0. req_ready returns to 1 in the cycle after done, so a request held valid is accepted every WR_WAIT+4 cycles for writes.
- R10: rsp_done is a single-cycle pulse.
- R11: mem_dq_drive is never 1 while mem_oe_n is 0. mem_oe_n falls only in a cycle whose previous cycle had mem_dq_drive at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 4 | Data to store on a write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read result, valid with rsp_done after a read |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 16 | Memory address bus |
| mem_dq_out | output | 4 | Value for the data pins when driven |
| mem_dq_drive | output | 1 | Enables the controller's data-pin drivers |
| mem_dq_in | input | 4 | Value seen on the data pins |

## Verification
The memory model in the bench returns the true word only on the last cycle of the read window and its complement before that. A controller that samples one cycle early therefore reads inverted data. The model stores a marker value whenever a write strobe arrives while the drivers are off, and it keys every word by the full 16-bit address. As a result, a shortened write window, an undriven bus, an early address swap or an address that changes after acceptance all show up as a wrong read-back. Separate port monitors count strobe cycles, catch a select that falls before the address has settled, catch a write strobe that releases together with select, and catch any cycle where the drivers and the memory outputs are on at once. A held-valid run then checks that a fresh request is taken only after the quiet recovery cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int SRAM_AW = 16;
    localparam int SRAM_DW = 4;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_ACCESS  = 3'd2,
        ST_HOLD    = 3'd3,
        ST_RECOVER = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    typedef struct packed {
        logic               is_wr;
        logic [SRAM_AW-1:0] addr;
        logic [SRAM_DW-1:0] wdata;
    } xfer_t;

    localparam strobe_t STROBE_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    function automatic strobe_t strobes_for(seq_state_t st, logic is_wr);
        strobe_t s;
        s = STROBE_QUIET;
        case (st)
            ST_SETUP: begin
                s.drive = is_wr;
            end
            ST_ACCESS: begin
                s.ce_n  = 1'b0;
                s.we_n  = ~is_wr;
                s.oe_n  = is_wr;
                s.drive = is_wr;
            end
            ST_HOLD: begin
                s.ce_n  = 1'b0;
                s.drive = 1'b1;
            end
            default: s = STROBE_QUIET;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int RD_WAIT = 3,
    parameter int WR_WAIT = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    is_wr,
    output logic    accept,
    output logic    capture,
    output logic    ready,
    output logic    done,
    output strobe_t strobes
);

    localparam int MAXW = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
    localparam int CW   = (MAXW < 2) ? 1 : $clog2(MAXW);
    localparam logic [CW-1:0] RD_LOAD = CW'(RD_WAIT - 1);
    localparam logic [CW-1:0] WR_LOAD = CW'(WR_WAIT - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          last_wait;

    assign last_wait = (state_q == ST_ACCESS) && (cnt_q == '0);
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign capture   = last_wait && !is_wr;
    assign ready     = (state_q == ST_IDLE);
    assign done      = (state_q == ST_RECOVER);
    assign strobes   = strobes_for(state_q, is_wr);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                state_d = ST_ACCESS;
                cnt_d   = is_wr ? WR_LOAD : RD_LOAD;
            end
            ST_ACCESS: begin
                if (cnt_q == '0) begin
                    state_d = is_wr ? ST_HOLD : ST_RECOVER;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HOLD:    state_d = ST_RECOVER;
            ST_RECOVER: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath
    import asram_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic               capture,
    input  xfer_t              req,
    input  logic [SRAM_DW-1:0] dq_in,
    output xfer_t              cur,
    output logic [SRAM_DW-1:0] rdata
);

    xfer_t              cur_q;
    logic [SRAM_DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (accept)  cur_q   <= req;
            if (capture) rdata_q <= dq_in;
        end
    end

    assign cur   = cur_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int RD_WAIT = 3,
    parameter int WR_WAIT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [SRAM_AW-1:0] req_addr,
    input  logic [SRAM_DW-1:0] req_wdata,
    output logic               rsp_done,
    output logic [SRAM_DW-1:0] rsp_rdata,
    output logic               mem_ce_n,
    output logic               mem_we_n,
    output logic               mem_oe_n,
    output logic [SRAM_AW-1:0] mem_addr,
    output logic [SRAM_DW-1:0] mem_dq_out,
    output logic               mem_dq_drive,
    input  logic [SRAM_DW-1:0] mem_dq_in
);

    logic    accept;
    logic    capture;
    strobe_t strobes;
    xfer_t   req_in;
    xfer_t   cur;

    assign req_in = '{is_wr: req_write, addr: req_addr, wdata: req_wdata};

    asram_seq #(
        .RD_WAIT (RD_WAIT),
        .WR_WAIT (WR_WAIT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .is_wr     (cur.is_wr),
        .accept    (accept),
        .capture   (capture),
        .ready     (req_ready),
        .done      (rsp_done),
        .strobes   (strobes)
    );

    asram_dpath u_dpath (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .capture (capture),
        .req     (req_in),
        .dq_in   (mem_dq_in),
        .cur     (cur),
        .rdata   (rsp_rdata)
    );

    assign mem_ce_n     = strobes.ce_n;
    assign mem_we_n     = strobes.we_n;
    assign mem_oe_n     = strobes.oe_n;
    assign mem_dq_drive = strobes.drive;
    assign mem_addr     = cur.addr;
    assign mem_dq_out   = cur.wdata;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_done,
    input logic        mem_ce_n,
    input logic        mem_we_n,
    input logic        mem_oe_n,
    input logic [15:0] mem_addr,
    input logic [3:0]  mem_dq_out,
    input logic        mem_dq_drive
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_drive));

    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_addr_setup_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> $stable(mem_addr));

    p_we_inside_ce_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_drive));

    p_we_hold_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_drive && $stable(mem_addr) && $stable(mem_dq_out)));

    p_read_window_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_drive && !req_ready));

    p_ready_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> req_ready);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_no_contention_r11: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_drive);

    p_turnaround_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> !$past(mem_dq_drive));

endmodule

bind asram_ctrl asram_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_done     (rsp_done),
    .mem_ce_n     (mem_ce_n),
    .mem_we_n     (mem_we_n),
    .mem_oe_n     (mem_oe_n),
    .mem_addr     (mem_addr),
    .mem_dq_out   (mem_dq_out),
    .mem_dq_drive (mem_dq_drive)
);

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;

    localparam int RD_WAIT = 3;
    localparam int WR_WAIT = 2;
    localparam int NVEC    = 10;

    // {write, addr, wdata, expected read data}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 16'h0000, 4'h5, 4'h0},
        {1'b1, 16'hFFFF, 4'hA, 4'h0},
        {1'b1, 16'h1234, 4'h3, 4'h0},
        {1'b0, 16'h0000, 4'h0, 4'h5},
        {1'b0, 16'hFFFF, 4'h0, 4'hA},
        {1'b1, 16'h1234, 4'hC, 4'h0},
        {1'b0, 16'h1234, 4'h0, 4'hC},
        {1'b1, 16'h0034, 4'h9, 4'h0},
        {1'b0, 16'h1234, 4'h0, 4'hC},
        {1'b0, 16'h0034, 4'h0, 4'h9}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        rsp_done;
    logic [3:0]  rsp_rdata;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive;
    logic [15:0] mem_addr;
    logic [3:0]  mem_dq_out;
    logic [3:0]  mem_dq_in = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    asram_ctrl #(.RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
    );

    // memory model and port monitors, all evaluated mid-cycle
    logic [3:0]  mdl [logic [15:0]];
    int          oe_run = 0;
    int          we_low_tot = 0, oe_low_tot = 0;
    int          ce_fall_tot = 0, ce_fall_bad = 0;
    int          we_rise_tot = 0, we_rise_bad = 0;
    int          clash_tot = 0;
    logic        prev_ce = 1'b1, prev_we = 1'b1, prev_oe = 1'b1, prev_drv = 1'b0;
    logic [15:0] prev_addr = '0;
    logic [3:0]  prev_dout = '0;

    function automatic logic [3:0] peek(logic [15:0] a);
        if (mdl.exists(a)) return mdl[a];
        return 4'h0;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_ce_n && !mem_we_n) begin
                we_low_tot++;
                mdl[mem_addr] = mem_dq_drive ? mem_dq_out : 4'hE;
            end
            if (!mem_ce_n && mem_we_n && !mem_oe_n) begin
                oe_run++;
                oe_low_tot++;
                mem_dq_in = (oe_run == RD_WAIT) ? peek(mem_addr) : ~peek(mem_addr);
            end else begin
                oe_run = 0;
                mem_dq_in = 4'h0;
            end
            if (prev_ce && !mem_ce_n) begin
                ce_fall_tot++;
                if (mem_addr != prev_addr) ce_fall_bad++;
            end
            if (!prev_we && mem_we_n) begin
                we_rise_tot++;
                if (mem_ce_n || !mem_dq_drive || mem_addr != prev_addr || mem_dq_out != prev_dout)
                    we_rise_bad++;
            end
            if ((!mem_oe_n && mem_dq_drive) || (prev_oe && !mem_oe_n && prev_drv)) clash_tot++;
        end
        prev_ce = mem_ce_n; prev_we = mem_we_n; prev_oe = mem_oe_n;
        prev_drv = mem_dq_drive; prev_addr = mem_addr; prev_dout = mem_dq_out;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic run_xfer(input logic wr, input logic [15:0] a, input logic [3:0] d,
                            input logic [3:0] exp, input bit check_rd);
        int we0, oe0, cf0, cfb0, wr0, wrb0, cl0, lat, busy_bad;
        while (!req_ready) @(negedge clk);
        we0 = we_low_tot; oe0 = oe_low_tot; cf0 = ce_fall_tot; cfb0 = ce_fall_bad;
        wr0 = we_rise_tot; wrb0 = we_rise_bad; cl0 = clash_tot;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
        lat = 1; busy_bad = 0;
        while (!rsp_done && lat < 40) begin
            if (req_ready) busy_bad++;
            @(negedge clk);
            lat++;
        end
        if (req_ready) busy_bad++;
        chk("R2 ready low while busy", busy_bad, 0);
        chk("R8 done latency", lat, wr ? WR_WAIT + 3 : RD_WAIT + 2);
        chk("R9 quiet strobes in done cycle",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive}, 4'b1110);
        if (wr) begin
            chk("R4 write strobe cycles", we_low_tot - we0, WR_WAIT);
            chk("R4 no read window on write", oe_low_tot - oe0, 0);
            chk("R5 write hold before deselect", (we_rise_tot - wr0) * 16 + (we_rise_bad - wrb0), 16);
        end else begin
            chk("R6 read window cycles", oe_low_tot - oe0, RD_WAIT);
            chk("R6 no write strobe on read", we_low_tot - we0, 0);
            if (check_rd) chk("R7 read data", rsp_rdata, exp);
        end
        chk("R3 address set before select", (ce_fall_tot - cf0) * 16 + (ce_fall_bad - cfb0), 16);
        chk("R11 no bus clash", clash_tot - cl0, 0);
        @(negedge clk);
        chk("R10 done is one cycle", rsp_done, 0);
        chk("R9 ready after done", req_ready, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int acc;
        // R1: reset and idle state
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive, req_ready, rsp_done}, 6'b111010);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R1 idle after reset",
                {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive, req_ready, rsp_done}, 6'b111010);
        end

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            run_xfer(VEC[v][24], VEC[v][23:8], VEC[v][7:4], VEC[v][3:0], 1'b1);
        end

        // R2: inputs changed after acceptance must not leak into the transfer
        run_xfer(1'b1, 16'h4242, 4'h6, 4'h0, 1'b0);
        run_xfer(1'b0, 16'h4242, 4'h0, 4'h6, 1'b1);
        run_xfer(1'b0, 16'hBDBD, 4'h0, 4'h0, 1'b1);
        chk("R2 late address and data ignored", peek(16'h4242) * 16 + peek(16'hBDBD), 16'h60);

        // R9: held-valid writes are taken once per WR_WAIT+4 cycles
        acc = 0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0777; req_wdata = 4'h3;
        for (int c = 0; c < 4 * (WR_WAIT + 4); c++) begin
            if (req_valid && req_ready) begin
                acc++;
                if (!(mem_ce_n && mem_we_n && mem_oe_n)) acc += 100;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R9 back-to-back acceptance count", acc, 4);
        while (!req_ready) @(negedge clk);
        run_xfer(1'b0, 16'h0777, 4'h0, 4'h3, 1'b1);

        // R1: long idle keeps the memory deselected
        acc = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (!mem_ce_n || rsp_done) acc++;
        end
        chk("R1 deselected while idle", acc, 0);

        finish_run();
    end

endmodule